// File: doc/BRIEF.md
# CompactFlash Sector Read Sequencer

This block is a bus-master state machine that fetches a run of 512-byte sectors from a removable-card storage controller. The controller is reached through a 16-bit register port whose addresses are byte offsets. A caller supplies a 28-bit start block address and a sector count, then pulses a start strobe. The sequencer first claims the controller's access lock. It then waits until a card is present and the controller is ready for a command.

The request is cut into chunks of at most 256 sectors. For each chunk, the sequencer writes the block address and a read command, holds the controller's configuration engine in reset, and drains the data buffer one burst at a time. Each 16-bit data word leaves on a byte stream, low byte first. At the end it drops the configuration reset and frees the lock. It then raises a one-cycle done pulse together with a result code and the number of sectors delivered.

Top module: `cf_sector_reader`

## Requirements
- R1: A start with a sector count of 0 produces done in the very next cycle, with result code 0 and sector count 0, and makes no register access.
- R2: The first request after reset that has a nonzero count begins by writing 0x0001 to offset 0x00, which selects 16-bit bus mode. Later requests skip this write.
- R3: Before any transfer, the sequencer reads the control register (offset 0x18) and writes it back with bit 1 set and every other bit preserved. It then polls the status register (offset 0x04) until bit 1 (lock granted) reads 1.
- R4: If LOCK_POLLS status reads in a row show no grant, the request ends with result code 2 and makes no further write.
- R5: Once the lock is held, a status read with bit 4 (card present) at 0 ends the request with result code 1. The lock is then released.
- R6: Once the lock is held and a card is present, the sequencer polls for bit 8 (ready for command). If RDY_POLLS reads show it clear, the request ends with result code 3 and the lock is released.
- R7: Each chunk covers min(remaining, 256) sectors. It starts by writing the low 16 address bits to offset 0x10 and address bits 27:16, zero-extended, to offset 0x12. The next chunk's address is the previous one plus the chunk size.
- R8: The command write to offset 0x14 carries 0x0300 ORed with the chunk size modulo 256, so a 256-sector chunk writes 0x0300.
- R9: After each command write, the control register is read and written back with bit 7 set. After the chunk's last data word, it is read and written back with bit 7 cleared. Other bits are kept each time.
- R10: Every burst of WORDS_PER_BURST reads from offset 0x40 is preceded by status polls until bit 5 (buffer ready) reads 1. A sector takes BURSTS_PER_SECTOR bursts.
- R11: Each data word appears on the byte stream as two valid bytes in consecutive cycles, bits 7:0 first and bits 15:8 second, in read order.
- R12: A request ends with one done pulse. A successful request first releases the lock by writing the control register with bit 1 cleared. At done, the sectors output equals the count delivered: the requested count on success, 0 on any error. The result code is 0 for success, 1 for no card, 2 for lock timeout and 3 for not ready.
- R13: A start strobe while a request is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only when idle |
| lba_i | input | LBA_W | First sector address |
| count_i | input | CNT_W | Number of sectors to read |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_code_o | output | 2 | Result code, valid at done |
| sectors_o | output | CNT_W | Sectors delivered, valid at done |
| bus_req_o | output | 1 | Register access request, held until acknowledged |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | ADDR_W | Register byte offset |
| bus_wdata_o | output | 16 | Write data |
| bus_ack_i | input | 1 | Access completes at the clock edge where it is high |
| bus_rdata_i | input | 16 | Read data, valid with ack |
| byte_valid_o | output | 1 | Byte stream qualifier |
| byte_o | output | 8 | Byte stream data |

## Verification
Requests are tried with a zero count, a single sector at an address whose upper half is nonzero, three sectors with a second start strobe fired in the middle, and 257 sectors. The 257-sector request splits into a full chunk and a one-sector chunk, which separates correct zero-means-256 command coding and address stepping from an off-by-one chunk split. Status patterns that withhold the lock, drop the card, or never report ready each take a different exit. Comparing the exact poll count and the exact list of register writes tells apart a missing lock release, a release after a lock timeout that should not happen, and a retry limit that is one too many or one too few. A controller model that only arms the data buffer after a ready status shows whether a burst ever starts without its ready poll. Random-length acknowledge delays show whether requests stay stable while waiting.

// File: rtl/cf_rd_pkg.sv
package cf_rd_pkg;
  localparam int WORD_W = 16;

  localparam logic [7:0] REG_MODE   = 8'h00;
  localparam logic [7:0] REG_STAT   = 8'h04;
  localparam logic [7:0] REG_LBA_LO = 8'h10;
  localparam logic [7:0] REG_LBA_HI = 8'h12;
  localparam logic [7:0] REG_CMD    = 8'h14;
  localparam logic [7:0] REG_CTRL   = 8'h18;
  localparam logic [7:0] REG_DATA   = 8'h40;

  localparam int CTL_LOCK   = 1;
  localparam int CTL_CFGRST = 7;
  localparam int ST_LOCK    = 1;
  localparam int ST_CARD    = 4;
  localparam int ST_BUF     = 5;
  localparam int ST_RDY     = 8;

  localparam logic [WORD_W-1:0] CMD_READ = 16'h0300;
  localparam logic [WORD_W-1:0] MODE_16  = 16'h0001;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_NO_CARD   = 2'd1,
    ERR_LOCK      = 2'd2,
    ERR_NOT_READY = 2'd3
  } err_e;

  typedef enum logic [4:0] {
    S_IDLE, S_MODE, S_LK_RD, S_LK_WR, S_LK_POLL, S_RDY_POLL,
    S_LBA_LO, S_LBA_HI, S_CMD, S_RST_RD, S_RST_WR, S_BUF_POLL,
    S_DATA, S_UNR_RD, S_UNR_WR, S_REL_RD, S_REL_WR, S_FIN
  } st_e;
endpackage

// File: rtl/cf_bus_port.sv
module cf_bus_port import cf_rd_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [WORD_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [WORD_W-1:0] bus_rdata_i
);
  logic              req_q, we_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (req_q) begin
        if (bus_ack_i) begin
          req_q   <= 1'b0;
          done_q  <= 1'b1;
          rdata_q <= bus_rdata_i;
        end
      end else if (go_i) begin
        req_q   <= 1'b1;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end

  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                   $stable(bus_wdata_o) && $stable(bus_we_o)));
  // R3
  go_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (!bus_req_o && !done_o));
endmodule

// File: rtl/cf_chunk_calc.sv
module cf_chunk_calc import cf_rd_pkg::*; #(
  parameter int LBA_W     = 28,
  parameter int CNT_W     = 16,
  parameter int CHUNK_MAX = 256,
  localparam int CHK_W    = $clog2(CHUNK_MAX + 1),
  localparam int FLD_W    = $clog2(CHUNK_MAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              adv_i,
  output logic [WORD_W-1:0] lba_lo_o,
  output logic [WORD_W-1:0] lba_hi_o,
  output logic [CNT_W-1:0]  remain_o,
  output logic [CHK_W-1:0]  chunk_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic              last_o
);
  logic [LBA_W-1:0] lba_q;
  logic [CNT_W-1:0] remain_q;
  logic [CHK_W-1:0] chunk;

  always_comb begin
    if (remain_q > CNT_W'(CHUNK_MAX)) chunk = CHK_W'(CHUNK_MAX);
    else                              chunk = CHK_W'(remain_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lba_q    <= '0;
      remain_q <= '0;
    end else if (load_i) begin
      lba_q    <= lba_i;
      remain_q <= cnt_i;
    end else if (adv_i) begin
      lba_q    <= lba_q + LBA_W'(chunk);
      remain_q <= remain_q - CNT_W'(chunk);
    end
  end

  assign lba_lo_o = lba_q[15:0];
  assign lba_hi_o = WORD_W'(lba_q[LBA_W-1:16]);
  assign remain_o = remain_q;
  assign chunk_o  = chunk;
  // count field wraps: a full chunk encodes as zero
  assign cmd_o    = CMD_READ | WORD_W'(chunk[FLD_W-1:0]);
  assign last_o   = (remain_q == CNT_W'(chunk));

  // R7
  chunk_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_o != '0) |-> (chunk_o != '0 && chunk_o <= CHK_W'(CHUNK_MAX)));
  // R7
  adv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (remain_o == $past(remain_o) - CNT_W'($past(chunk_o))));
endmodule

// File: rtl/cf_byte_ser.sv
module cf_byte_ser import cf_rd_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              vld_o,
  output logic [7:0]        byte_o
);
  logic       hi_pend_q, vld_q;
  logic [7:0] hi_q, byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_pend_q <= 1'b0;
      vld_q     <= 1'b0;
      hi_q      <= '0;
      byte_q    <= '0;
    end else if (load_i) begin
      byte_q    <= word_i[7:0];
      hi_q      <= word_i[15:8];
      vld_q     <= 1'b1;
      hi_pend_q <= 1'b1;
    end else if (hi_pend_q) begin
      byte_q    <= hi_q;
      vld_q     <= 1'b1;
      hi_pend_q <= 1'b0;
    end else begin
      vld_q     <= 1'b0;
    end
  end

  assign vld_o  = vld_q;
  assign byte_o = byte_q;

  // R11
  load_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !hi_pend_q);
  // R11
  pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> vld_o ##1 vld_o);
endmodule

// File: rtl/cf_sector_reader.sv
module cf_sector_reader import cf_rd_pkg::*; #(
  parameter int LBA_W             = 28,
  parameter int CNT_W             = 16,
  parameter int ADDR_W            = 8,
  parameter int CHUNK_MAX         = 256,
  parameter int WORDS_PER_BURST   = 16,
  parameter int BURSTS_PER_SECTOR = 16,
  parameter int LOCK_POLLS        = 12,
  parameter int RDY_POLLS         = 2002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_code_o,
  output logic [CNT_W-1:0]  sectors_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [15:0]       bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [15:0]       bus_rdata_i,
  output logic              byte_valid_o,
  output logic [7:0]        byte_o
);
  localparam int CHK_W  = $clog2(CHUNK_MAX + 1);
  localparam int BST_W  = $clog2(CHUNK_MAX * BURSTS_PER_SECTOR + 1);
  localparam int WRD_W  = $clog2(WORDS_PER_BURST + 1);
  localparam int PMAX   = (LOCK_POLLS > RDY_POLLS) ? LOCK_POLLS : RDY_POLLS;
  localparam int POLL_W = $clog2(PMAX + 1);

  st_e               state_q;
  err_e              err_q;
  logic              pend_q, mode_set_q;
  logic [WORD_W-1:0] ctrl_q;
  logic [POLL_W-1:0] poll_q;
  logic [BST_W-1:0]  burst_q;
  logic [WRD_W-1:0]  word_q;
  logic [CNT_W-1:0]  sectors_q;

  logic              acc, go, we, done;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] wdata, rd;
  logic              load, adv, idle_start;
  logic [WORD_W-1:0] lba_lo, lba_hi, cmd;
  logic [CNT_W-1:0]  remain;
  logic [CHK_W-1:0]  chunk;
  logic              last;

  assign idle_start = (state_q == S_IDLE) && start_i;
  assign load       = idle_start && (count_i != '0);
  assign adv        = (state_q == S_UNR_WR) && done;

  always_comb begin
    acc   = 1'b1;
    we    = 1'b0;
    addr  = ADDR_W'(REG_STAT);
    wdata = '0;
    unique case (state_q)
      S_MODE:   begin we = 1'b1; addr = ADDR_W'(REG_MODE); wdata = MODE_16; end
      S_LK_RD, S_RST_RD, S_UNR_RD, S_REL_RD:
                addr = ADDR_W'(REG_CTRL);
      S_LK_WR:  begin we = 1'b1; addr = ADDR_W'(REG_CTRL); wdata = ctrl_q | (16'h1 << CTL_LOCK); end
      S_RST_WR: begin we = 1'b1; addr = ADDR_W'(REG_CTRL); wdata = ctrl_q | (16'h1 << CTL_CFGRST); end
      S_UNR_WR: begin we = 1'b1; addr = ADDR_W'(REG_CTRL); wdata = ctrl_q & ~(16'h1 << CTL_CFGRST); end
      S_REL_WR: begin we = 1'b1; addr = ADDR_W'(REG_CTRL); wdata = ctrl_q & ~(16'h1 << CTL_LOCK); end
      S_LK_POLL, S_RDY_POLL, S_BUF_POLL:
                addr = ADDR_W'(REG_STAT);
      S_LBA_LO: begin we = 1'b1; addr = ADDR_W'(REG_LBA_LO); wdata = lba_lo; end
      S_LBA_HI: begin we = 1'b1; addr = ADDR_W'(REG_LBA_HI); wdata = lba_hi; end
      S_CMD:    begin we = 1'b1; addr = ADDR_W'(REG_CMD); wdata = cmd; end
      S_DATA:   addr = ADDR_W'(REG_DATA);
      default:  acc = 1'b0;
    endcase
  end

  assign go = acc && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      err_q      <= ERR_NONE;
      pend_q     <= 1'b0;
      mode_set_q <= 1'b0;
      ctrl_q     <= '0;
      poll_q     <= '0;
      burst_q    <= '0;
      word_q     <= '0;
      sectors_q  <= '0;
    end else begin
      if (go) pend_q <= 1'b1;
      if (done) pend_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          err_q     <= ERR_NONE;
          sectors_q <= '0;
          if (count_i == '0)   state_q <= S_FIN;
          else if (mode_set_q) state_q <= S_LK_RD;
          else                 state_q <= S_MODE;
        end
        S_MODE: if (done) begin
          mode_set_q <= 1'b1;
          state_q    <= S_LK_RD;
        end
        S_LK_RD: if (done) begin
          ctrl_q  <= rd;
          state_q <= S_LK_WR;
        end
        S_LK_WR: if (done) begin
          poll_q  <= '0;
          state_q <= S_LK_POLL;
        end
        S_LK_POLL: if (done) begin
          if (rd[ST_LOCK]) begin
            poll_q  <= '0;
            state_q <= S_RDY_POLL;
          end else if (poll_q == POLL_W'(LOCK_POLLS - 1)) begin
            err_q   <= ERR_LOCK;
            state_q <= S_FIN;
          end else begin
            poll_q  <= poll_q + 1'b1;
          end
        end
        S_RDY_POLL: if (done) begin
          if (!rd[ST_CARD]) begin
            err_q   <= ERR_NO_CARD;
            state_q <= S_REL_RD;
          end else if (rd[ST_RDY]) begin
            state_q <= S_LBA_LO;
          end else if (poll_q == POLL_W'(RDY_POLLS - 1)) begin
            err_q   <= ERR_NOT_READY;
            state_q <= S_REL_RD;
          end else begin
            poll_q  <= poll_q + 1'b1;
          end
        end
        S_LBA_LO: if (done) state_q <= S_LBA_HI;
        S_LBA_HI: if (done) state_q <= S_CMD;
        S_CMD: if (done) begin
          burst_q <= BST_W'(chunk) * BST_W'(BURSTS_PER_SECTOR);
          state_q <= S_RST_RD;
        end
        S_RST_RD: if (done) begin
          ctrl_q  <= rd;
          state_q <= S_RST_WR;
        end
        S_RST_WR: if (done) state_q <= S_BUF_POLL;
        S_BUF_POLL: if (done && rd[ST_BUF]) begin
          word_q  <= '0;
          state_q <= S_DATA;
        end
        S_DATA: if (done) begin
          if (word_q == WRD_W'(WORDS_PER_BURST - 1)) begin
            burst_q <= burst_q - 1'b1;
            state_q <= (burst_q == BST_W'(1)) ? S_UNR_RD : S_BUF_POLL;
          end else begin
            word_q  <= word_q + 1'b1;
          end
        end
        S_UNR_RD: if (done) begin
          ctrl_q  <= rd;
          state_q <= S_UNR_WR;
        end
        S_UNR_WR: if (done) begin
          sectors_q <= sectors_q + CNT_W'(chunk);
          state_q   <= last ? S_REL_RD : S_LBA_LO;
        end
        S_REL_RD: if (done) begin
          ctrl_q  <= rd;
          state_q <= S_REL_WR;
        end
        S_REL_WR: if (done) state_q <= S_FIN;
        S_FIN: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  cf_bus_port #(.ADDR_W(ADDR_W)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .we_i        (we),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .done_o      (done),
    .rdata_o     (rd),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i),
    .bus_rdata_i (bus_rdata_i)
  );

  cf_chunk_calc #(.LBA_W(LBA_W), .CNT_W(CNT_W), .CHUNK_MAX(CHUNK_MAX)) u_chunk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .lba_i    (lba_i),
    .cnt_i    (count_i),
    .adv_i    (adv),
    .lba_lo_o (lba_lo),
    .lba_hi_o (lba_hi),
    .remain_o (remain),
    .chunk_o  (chunk),
    .cmd_o    (cmd),
    .last_o   (last)
  );

  cf_byte_ser u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (done && (state_q == S_DATA)),
    .word_i (rd),
    .vld_o  (byte_valid_o),
    .byte_o (byte_o)
  );

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_FIN);
  assign err_code_o = err_q;
  assign sectors_o  = sectors_q;

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R1
  zero_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && count_i == '0) |=> (done_o && err_code_o == 2'd0 && sectors_o == '0));
  // R11
  byte_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> busy_o);
  // R12
  err_sectors_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_code_o != 2'd0) |-> (sectors_o == '0));
  // R13
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);
  // R8
  remain_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CMD) |-> (remain != '0));
endmodule

// File: tb/cf_sector_reader_test.sv
module cf_sector_reader_test;
  localparam int WPB   = 2;
  localparam int BPS   = 1;
  localparam int RDYP  = 20;
  localparam int LOCKP = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [27:0] lba_i = '0;
  logic [15:0] count_i = '0;
  logic        busy_o, done_o, bus_req_o, bus_we_o, byte_valid_o;
  logic [1:0]  err_code_o;
  logic [15:0] sectors_o, bus_wdata_o;
  logic [7:0]  bus_addr_o, byte_o;
  logic        bus_ack_i = 1'b0;
  logic [15:0] bus_rdata_i = '0;

  always #5 clk = ~clk;

  cf_sector_reader #(
    .WORDS_PER_BURST(WPB), .BURSTS_PER_SECTOR(BPS),
    .LOCK_POLLS(LOCKP), .RDY_POLLS(RDYP)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .lba_i(lba_i),
    .count_i(count_i), .busy_o(busy_o), .done_o(done_o),
    .err_code_o(err_code_o), .sectors_o(sectors_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i),
    .bus_rdata_i(bus_rdata_i), .byte_valid_o(byte_valid_o), .byte_o(byte_o)
  );

  int checks = 0;
  int fails  = 0;
  logic [23:0] exp_wr[$];
  logic [7:0]  exp_byte[$];

  // controller model state
  logic [15:0] ctrl_m = 16'h1000;
  bit card_m = 1, lock_ok_m = 1, rdy_ok_m = 1, buf_tog = 0;
  int lock_wait_m = 2;
  int lock_reads = 0, stat_reads = 0, acc_n = 0, wait_ct = 0, armed = 0;
  int data_k = 0, exp_k = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input int k);
    return 16'(k) * 16'h9E37 + 16'h0101;
  endfunction

  // controller model: acknowledge with 0..2 cycle delay
  always @(negedge clk) begin
    if (bus_ack_i) begin
      bus_ack_i = 1'b0;
    end else if (bus_req_o) begin
      if (wait_ct < acc_n % 3) begin
        wait_ct++;
      end else begin
        wait_ct = 0;
        acc_n++;
        if (bus_we_o) begin
          if (exp_wr.size() == 0) begin
            chk(0, "R3 R7 R8 R9 R12", "unexpected write", {bus_addr_o, bus_wdata_o}, 0);
          end else begin
            logic [23:0] e;
            e = exp_wr.pop_front();
            chk({bus_addr_o, bus_wdata_o} == e, "R2 R3 R7 R8 R9 R12 R13", "write addr/data",
                {bus_addr_o, bus_wdata_o}, e);
          end
          if (bus_addr_o == 8'h18) ctrl_m = bus_wdata_o;
        end else begin
          case (bus_addr_o)
            8'h18: bus_rdata_i = ctrl_m;
            8'h04: begin
              logic gr;
              stat_reads++;
              if (ctrl_m[1]) lock_reads++;
              gr = ctrl_m[1] && lock_ok_m && (lock_reads > lock_wait_m);
              bus_rdata_i = {7'b0, rdy_ok_m, 2'b0, buf_tog, card_m, 2'b0, gr, 1'b0};
              if (buf_tog) armed = WPB;
              buf_tog = ~buf_tog;
            end
            8'h40: begin
              if (armed == 0) chk(0, "R10", "data read without buffer ready", 32'(armed), 1);
              else armed--;
              bus_rdata_i = word_of(data_k);
              data_k++;
            end
            default: begin
              bus_rdata_i = 16'hDEAD;
              chk(0, "R3", "read of unexpected offset", 32'(bus_addr_o), 0);
            end
          endcase
        end
        bus_ack_i = 1'b1;
      end
    end
  end

  // byte monitor
  always @(negedge clk) begin
    if (rst_ni && byte_valid_o) begin
      if (exp_byte.size() == 0) begin
        chk(0, "R11", "unexpected byte", 32'(byte_o), 0);
      end else begin
        logic [7:0] b;
        b = exp_byte.pop_front();
        chk(byte_o == b, "R11", "byte value/order", 32'(byte_o), 32'(b));
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic push_wr(input logic [7:0] a, input logic [15:0] d);
    exp_wr.push_back({a, d});
  endtask

  task automatic plan_ok(input logic [27:0] lba, input int cnt, input bit first);
    logic [15:0] c;
    logic [27:0] l;
    int rem;
    c = ctrl_m;
    l = lba;
    rem = cnt;
    if (first) push_wr(8'h00, 16'h0001);
    push_wr(8'h18, c | 16'h0002);
    while (rem > 0) begin
      int ch;
      ch = (rem > 256) ? 256 : rem;
      push_wr(8'h10, l[15:0]);
      push_wr(8'h12, {4'b0, l[27:16]});
      push_wr(8'h14, 16'h0300 | 16'(ch % 256));
      push_wr(8'h18, c | 16'h0082);
      push_wr(8'h18, c | 16'h0002);
      for (int w = 0; w < ch * BPS * WPB; w++) begin
        logic [15:0] v;
        v = word_of(exp_k);
        exp_k++;
        exp_byte.push_back(v[7:0]);
        exp_byte.push_back(v[15:8]);
      end
      l = l + 28'(ch);
      rem = rem - ch;
    end
    push_wr(8'h18, c & ~16'h0002);
  endtask

  task automatic plan_err(input bit with_release);
    logic [15:0] c;
    c = ctrl_m;
    push_wr(8'h18, c | 16'h0002);
    if (with_release) push_wr(8'h18, c & ~16'h0002);
  endtask

  task automatic fire(input logic [27:0] lba, input int cnt, input logic [1:0] e_err,
                      input int e_sec, input int e_stat, input int poke, input string tag);
    int n;
    stat_reads = 0;
    lock_reads = 0;
    @(negedge clk);
    lba_i = lba;
    count_i = 16'(cnt);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 40000) begin
      @(negedge clk);
      n++;
      if (poke > 0 && n == poke) begin
        // R13: stray start while busy
        chk(busy_o, "R13", "busy during run", 32'(busy_o), 1);
        start_i = 1'b1;
        count_i = 16'd7;
        lba_i = 28'h0;
      end else begin
        start_i = 1'b0;
      end
    end
    chk(done_o, tag, "done pulse seen", 32'(done_o), 1);
    chk(err_code_o == e_err, tag, "result code", 32'(err_code_o), 32'(e_err));
    chk(sectors_o == 16'(e_sec), "R12", "sectors at done", 32'(sectors_o), 32'(e_sec));
    if (e_stat >= 0) chk(stat_reads == e_stat, tag, "status poll count", 32'(stat_reads), 32'(e_stat));
    @(negedge clk);
    chk(!done_o, "R12", "done is one cycle", 32'(done_o), 0);
    chk(exp_wr.size() == 0, tag, "pending expected writes", 32'(exp_wr.size()), 0);
    chk(exp_byte.size() == 0, "R11", "pending expected bytes", 32'(exp_byte.size()), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state
    chk(!busy_o && !done_o && !bus_req_o && !byte_valid_o, "R12", "idle after reset",
        {busy_o, done_o, bus_req_o, byte_valid_o}, 0);
    chk(err_code_o == 2'd0 && sectors_o == 16'd0, "R12", "result regs after reset",
        {err_code_o, sectors_o}, 0);

    // R1: zero count, no bus traffic, done next cycle
    begin
      int a0;
      a0 = acc_n;
      lba_i = 28'h123;
      count_i = 16'd0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o, "R1", "done right after zero-count start", 32'(done_o), 1);
      chk(err_code_o == 2'd0 && sectors_o == 16'd0, "R1", "zero-count result",
          {err_code_o, sectors_o}, 0);
      repeat (4) @(negedge clk);
      chk(acc_n == a0, "R1", "no access for zero count", 32'(acc_n), 32'(a0));
    end

    // R2 R3 R7 R8 R9 R10 R11: one sector, high LBA half nonzero
    plan_ok(28'hABCDEF1, 1, 1);
    fire(28'hABCDEF1, 1, 2'd0, 1, -1, 0, "R3");

    // R13: three sectors, stray start mid-run; no mode write (R2)
    lock_wait_m = 0;
    plan_ok(28'h0FFFFFE, 3, 0);
    fire(28'h0FFFFFE, 3, 2'd0, 3, -1, 25, "R13");

    // R7 R8: 257 sectors -> full chunk (field 0) then one sector
    plan_ok(28'h0000100, 257, 0);
    fire(28'h0000100, 257, 2'd0, 257, -1, 0, "R8");

    // R5: card missing after lock
    lock_wait_m = 1;
    card_m = 0;
    plan_err(1);
    fire(28'h55, 4, 2'd1, 0, 3, 0, "R5");
    card_m = 1;

    // R6: never ready
    rdy_ok_m = 0;
    plan_err(1);
    fire(28'h66, 4, 2'd3, 0, 2 + RDYP, 0, "R6");
    rdy_ok_m = 1;

    // R4: lock never granted, no release write
    lock_ok_m = 0;
    plan_err(0);
    fire(28'h77, 4, 2'd2, 0, LOCKP, 0, "R4");
    lock_ok_m = 1;
    chk(ctrl_m == 16'h1002, "R4", "lock bit left as written", 32'(ctrl_m), 32'h1002);
    ctrl_m = 16'h1000;

    // recovery run after errors
    lock_wait_m = 0;
    plan_ok(28'h000FFFF, 2, 0);
    fire(28'h000FFFF, 2, 2'd0, 2, -1, 0, "R7");
    chk(ctrl_m == 16'h1000, "R12", "lock released at end", 32'(ctrl_m), 32'h1000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule